// File: doc/BRIEF.md
# Triplexed LCD segment driver

This block drives a liquid crystal display multiplexed over three backplanes (1/3 duty, 1/3 bias). The display shows four full decimal digits, a leading half digit ("1"), a minus sign, four decimal points and two annunciators (continuity and low battery). Each output is a 2-bit code that picks one of four analog drive levels. The level generators themselves sit outside the block.

A reading consists of four BCD digits, a half-digit flag and a polarity flag. It passes through a display latch with three modes: strobed, hold and transparent. In strobed mode the latch loads while a conversion strobe is low. In hold mode it keeps the last reading. In transparent mode it follows the live counter. Decimal points and the two annunciator flags are not latched.

Frame timing comes from the oscillator clock. A frame lasts 1200 clocks and is split into six slots of 200 clocks. Each backplane is active once per frame with each polarity. Every level is inverted in the second half of the frame, so the display sees no net DC.

Top module: `lcd_tri_drv`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the block is in slot 0: backplane 0 active, first half of the frame. The latched reading is all zeros, with the half digit and minus sign off.
- R2: Each slot lasts SLOT_LEN (200) clocks, and the six slots run in the order bp0, bp1, bp2 (first half), then bp0, bp1, bp2 (second half). One frame is 6*SLOT_LEN clocks. After k clocks since reset, the block is in slot (k / SLOT_LEN) mod 6.
- R3: Level codes are VDISP=00, VL=01, VH=10 and VDD=11. Backplane i is driven on bp_lvl[2i+1:2i]. In the first half, the active backplane is at VDD and the others are at VL. In the second half, the active backplane is at VDISP and the others are at VH. This holds whatever segments are lit.
- R4: In the first half, a segment line is at VDISP if its segment on the active backplane is lit, and at VH otherwise. In the second half it is at VDD if lit and at VL otherwise.
- R5: Digit d (d=0 least significant, BCD in live_bcd[4d+3:4d]) owns lines 3d, 3d+1 and 3d+2, where line j is driven on seg_lvl[2j+1:2j]. On backplanes 0, 1 and 2 respectively, line 3d carries (F, E, DP[d]), line 3d+1 carries (A, G, D), and line 3d+2 carries (B, C, extra).
- R6: The extra position is continuity for digit 0, low battery for digit 1, the minus sign for digit 2 and the half digit for digit 3.
- R7: BCD codes 0 to 9 light the usual seven-segment patterns. Codes 10 to 15 light no digit segment; the extra and DP positions are unaffected.
- R8: ann_lvl is VDISP during the first half of the frame and VDD during the second half. It is always the complement of the active backplane's level.
- R9: latch_mode=00 (strobed): the latch loads the live reading on each clock while strobe_n is low, and keeps its value while strobe_n is high.
- R10: latch_mode=01 or 11 (hold): the latch keeps its value whatever strobe_n and the live reading do.
- R11: latch_mode=10 (transparent): the display shows the live reading presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_bcd | input | 16 | Live counter digits, 4 bits per digit |
| live_half | input | 1 | Live leading half digit |
| live_neg | input | 1 | Live polarity, 1 = negative |
| latch_mode | input | 2 | 00 strobed, 01/11 hold, 10 transparent |
| strobe_n | input | 1 | Conversion strobe, low = load |
| dp_req | input | 4 | Decimal point requests, one per digit |
| cont_flag | input | 1 | Continuity annunciator on |
| lowbat_flag | input | 1 | Low-battery annunciator on |
| bp_lvl | output | 6 | Backplane level codes |
| seg_lvl | output | 24 | Segment-line level codes |
| ann_lvl | output | 2 | Annunciator square-wave level code |

## Verification
The bench probes the slot boundaries at the last and first clock of each slot and across the frame wrap. A timer that is off by one would show the wrong backplane at those points, and one that skipped the polarity swap would leave DC on the glass. It sweeps whole frames with patterns that separate every line group and every extra position, including blanked codes 10 to 15, so a swapped segment, backplane or annunciator shows up as a wrong line level. For the latch it presents a new reading with the strobe idle and under hold, and catches any design that leaks it through. It also checks that transparent mode takes exactly one clock.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    LV_VDISP = 2'b00,
    LV_VL    = 2'b01,
    LV_VH    = 2'b10,
    LV_VDD   = 2'b11
  } lvl_t;

  typedef enum logic [1:0] {
    LM_STROBED = 2'b00,
    LM_HOLD    = 2'b01,
    LM_TRANSP  = 2'b10,
    LM_HOLD2   = 2'b11
  } lmode_t;

  // Mirror a level about mid-supply: VDD<->VDISP, VH<->VL.
  function automatic lvl_t flip(input lvl_t l);
    return lvl_t'(~l);
  endfunction

  function automatic lvl_t bp_level(input logic active, input logic second_half);
    lvl_t l;
    l = active ? LV_VDD : LV_VL;
    return second_half ? flip(l) : l;
  endfunction

  function automatic lvl_t seg_level(input logic lit, input logic second_half);
    lvl_t l;
    l = lit ? LV_VDISP : LV_VH;
    return second_half ? flip(l) : l;
  endfunction

  // Returns {a,b,c,d,e,f,g}; codes above nine are dark.
  function automatic logic [6:0] seg7(input logic [3:0] v);
    case (v)
      4'd0: return 7'h7E;
      4'd1: return 7'h30;
      4'd2: return 7'h6D;
      4'd3: return 7'h79;
      4'd4: return 7'h33;
      4'd5: return 7'h5B;
      4'd6: return 7'h5F;
      4'd7: return 7'h70;
      4'd8: return 7'h7F;
      4'd9: return 7'h7B;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int SLOT_LEN = 200,
  parameter int NUM_BP   = 3,
  localparam int BP_W    = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int CNT_W   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [BP_W-1:0] act_bp,
  output logic            second_half,
  output logic            slot_end
);

  logic [CNT_W-1:0] cyc;
  logic             last_bp;

  assign slot_end = (cyc == CNT_W'(SLOT_LEN - 1));
  assign last_bp  = (act_bp == BP_W'(NUM_BP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc         <= '0;
      act_bp      <= '0;
      second_half <= 1'b0;
    end else if (slot_end) begin
      cyc <= '0;
      if (last_bp) begin
        act_bp      <= '0;
        second_half <= ~second_half;
      end else begin
        act_bp <= act_bp + BP_W'(1);
      end
    end else begin
      cyc <= cyc + CNT_W'(1);
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc < CNT_W'(SLOT_LEN));
  assert_bp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_bp < BP_W'(NUM_BP));
  assert_slot_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> ($stable(act_bp) && $stable(second_half)));
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !last_bp) |=> (act_bp == $past(act_bp) + BP_W'(1)) && $stable(second_half));
  assert_half_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && last_bp) |=> (act_bp == '0) && (second_half != $past(second_half)));

endmodule

// File: rtl/lcd_disp_latch.sv
module lcd_disp_latch
  import lcd_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         strobe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] shown,
  output logic         load_en
);

  lmode_t m;
  assign m       = lmode_t'(mode);
  assign load_en = (m == LM_TRANSP) || ((m == LM_STROBED) && !strobe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shown <= '0;
    else if (load_en) shown <= live;
  end

  assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == 1'b1) |=> $stable(shown));
  assert_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00) && strobe_n) |=> $stable(shown));
  assert_strobe_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00) && !strobe_n) |=> (shown == $past(live)));
  assert_transp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (shown == $past(live)));

endmodule

// File: rtl/lcd_seg_mapper.sv
module lcd_seg_mapper
  import lcd_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int LINES     = 3 * NUM_DIGITS
) (
  input  logic [4*NUM_DIGITS-1:0] bcd,
  input  logic                    half,
  input  logic                    neg,
  input  logic [NUM_DIGITS-1:0]   dp,
  input  logic                    cont,
  input  logic                    lowbat,
  output logic [LINES-1:0][2:0]   on_mtx
);

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic [6:0] s;
    logic       extra;
    assign s = seg7(bcd[4*d +: 4]);

    if (d == NUM_DIGITS - 1) begin : g_half
      assign extra = half;
    end else if (d == 0) begin : g_cont
      assign extra = cont;
    end else if (d == 1) begin : g_lowbat
      assign extra = lowbat;
    end else if (d == 2) begin : g_sign
      assign extra = neg;
    end else begin : g_none
      assign extra = 1'b0;
    end

    // index within each line = backplane number
    assign on_mtx[3*d]     = {dp[d], s[2], s[1]};   // F, E, DP
    assign on_mtx[3*d + 1] = {s[3], s[0], s[6]};    // A, G, D
    assign on_mtx[3*d + 2] = {extra, s[4], s[5]};   // B, C, extra

    always_comb begin
      if (bcd[4*d +: 4] > 4'd9) begin
        assert_blank_R7: assert (on_mtx[3*d][1:0] == 2'b00 && on_mtx[3*d + 1] == 3'b000
                                 && on_mtx[3*d + 2][1:0] == 2'b00);
      end
    end
  end

endmodule

// File: rtl/lcd_tri_drv.sv
module lcd_tri_drv
  import lcd_pkg::*;
#(
  parameter int SLOT_LEN   = 200,
  parameter int NUM_DIGITS = 4,
  localparam int NUM_BP    = 3,
  localparam int LINES     = 3 * NUM_DIGITS,
  localparam int RD_W      = 4 * NUM_DIGITS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4*NUM_DIGITS-1:0] live_bcd,
  input  logic                    live_half,
  input  logic                    live_neg,
  input  logic [1:0]              latch_mode,
  input  logic                    strobe_n,
  input  logic [NUM_DIGITS-1:0]   dp_req,
  input  logic                    cont_flag,
  input  logic                    lowbat_flag,
  output logic [2*NUM_BP-1:0]     bp_lvl,
  output logic [2*LINES-1:0]      seg_lvl,
  output logic [1:0]              ann_lvl
);

  logic [1:0]            act_bp;
  logic                  second_half;
  logic                  slot_end;
  logic                  load_en;
  logic [RD_W-1:0]       shown;
  logic [LINES-1:0][2:0] on_mtx;
  logic [NUM_BP-1:0]     bp_full;
  logic [1:0]            act_lvl;

  lcd_frame_timer #(.SLOT_LEN(SLOT_LEN), .NUM_BP(NUM_BP)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .act_bp(act_bp), .second_half(second_half), .slot_end(slot_end)
  );

  lcd_disp_latch #(.W(RD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .mode(latch_mode), .strobe_n(strobe_n),
    .live({live_neg, live_half, live_bcd}), .shown(shown), .load_en(load_en)
  );

  lcd_seg_mapper #(.NUM_DIGITS(NUM_DIGITS)) u_map (
    .bcd(shown[4*NUM_DIGITS-1:0]), .half(shown[4*NUM_DIGITS]),
    .neg(shown[4*NUM_DIGITS+1]), .dp(dp_req), .cont(cont_flag),
    .lowbat(lowbat_flag), .on_mtx(on_mtx)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    assign bp_lvl[2*i +: 2] = bp_level(act_bp == 2'(i), second_half);
    assign bp_full[i] = (bp_lvl[2*i +: 2] == LV_VDD) || (bp_lvl[2*i +: 2] == LV_VDISP);
  end

  assign act_lvl = bp_lvl[2*act_bp +: 2];

  for (genvar j = 0; j < LINES; j++) begin : g_line
    assign seg_lvl[2*j +: 2] = seg_level(on_mtx[j][act_bp], second_half);

    assert_seg_not_bp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seg_lvl[2*j +: 2] != act_lvl);
  end

  assign ann_lvl = second_half ? LV_VDD : LV_VDISP;

  assert_one_full_bp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bp_full) == 1);
  assert_ann_opposes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ann_lvl == ~act_lvl);
  assert_bp_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(second_half)) |-> (bp_lvl[1:0] == ~$past(bp_lvl[5:4])));

endmodule

// File: tb/tb_lcd_tri_drv.sv
module tb_lcd_tri_drv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] live_bcd = '0;
  logic        live_half = 1'b0, live_neg = 1'b0;
  logic [1:0]  latch_mode = 2'b10;
  logic        strobe_n = 1'b1;
  logic [3:0]  dp_req = '0;
  logic        cont_flag = 1'b0, lowbat_flag = 1'b0;
  logic [5:0]  bp_lvl;
  logic [23:0] seg_lvl;
  logic [1:0]  ann_lvl;

  int total = 0, bad = 0, k = 0;
  logic done = 1'b0;
  // bench model of the latched reading
  logic [15:0] m_dig = '0;
  logic        m_half = 1'b0, m_neg = 1'b0;

  lcd_tri_drv dut (
    .clk(clk), .rst_n(rst_n), .live_bcd(live_bcd), .live_half(live_half),
    .live_neg(live_neg), .latch_mode(latch_mode), .strobe_n(strobe_n),
    .dp_req(dp_req), .cont_flag(cont_flag), .lowbat_flag(lowbat_flag),
    .bp_lvl(bp_lvl), .seg_lvl(seg_lvl), .ann_lvl(ann_lvl)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (!rst_n) k <= 0; else k <= k + 1;

  // bit0=a ... bit6=g
  function automatic logic [6:0] b_seg(input logic [3:0] v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic e_on(input int line, input int b);
    int d, g; logic [6:0] s; logic ex;
    d = line / 3; g = line % 3; s = b_seg(m_dig[4*d +: 4]);
    case (d) 0: ex = cont_flag; 1: ex = lowbat_flag; 2: ex = m_neg; default: ex = m_half; endcase
    case (g)
      0: return (b == 0) ? s[5] : (b == 1) ? s[4] : dp_req[d];
      1: return (b == 0) ? s[0] : (b == 1) ? s[6] : s[3];
      default: return (b == 0) ? s[1] : (b == 1) ? s[2] : ex;
    endcase
  endfunction

  task automatic check_all(input string tag);
    int slot, act; logic [5:0] eb; logic [23:0] es; logic [1:0] ea;
    slot = (k / 200) % 6; act = slot % 3;
    for (int b = 0; b < 3; b++)
      eb[2*b +: 2] = (slot < 3) ? ((b == act) ? 2'd3 : 2'd1) : ((b == act) ? 2'd0 : 2'd2);
    for (int j = 0; j < 12; j++)
      es[2*j +: 2] = (slot < 3) ? (e_on(j, act) ? 2'd0 : 2'd2) : (e_on(j, act) ? 2'd3 : 2'd1);
    ea = (slot < 3) ? 2'd0 : 2'd3;
    total += 3;
    if (bp_lvl !== eb) begin bad++; $display("FAIL %s bp k=%0d got %h exp %h", tag, k, bp_lvl, eb); end
    if (seg_lvl !== es) begin bad++; $display("FAIL %s seg k=%0d got %h exp %h", tag, k, seg_lvl, es); end
    if (ann_lvl !== ea) begin bad++; $display("FAIL %s ann k=%0d got %h exp %h", tag, k, ann_lvl, ea); end
  endtask

  task automatic goto_k(input int n);
    do @(negedge clk); while (k < n);
  endtask

  task automatic check_frame(input string tag);
    for (int s = 0; s < 6; s++) begin
      do @(negedge clk); while ((k / 200) % 6 != s);
      check_all(tag);
    end
  endtask

  task automatic drive_live(input logic [15:0] v, input logic h, input logic n);
    live_bcd = v; live_half = h; live_neg = n;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    m_dig = '0; m_half = 1'b0; m_neg = 1'b0;
    latch_mode = 2'b01;
    @(negedge clk);
    total++;
    if (bp_lvl !== 6'b010111) begin bad++; $display("FAIL R1 bp in reset got %h exp %h", bp_lvl, 6'b010111); end
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check_all("R1 after release");
  endtask

  task automatic t_slot_timing();
    for (int s = 1; s <= 6; s++) begin
      goto_k(200 * s - 1); check_all("R2 R3 slot end");
      goto_k(200 * s);     check_all("R2 R3 slot start");
    end
  endtask

  task automatic t_digits();
    latch_mode = 2'b10;
    drive_live(16'h9876, 1'b1, 1'b0); @(negedge clk);
    m_dig = 16'h9876; m_half = 1'b1; m_neg = 1'b0;
    check_frame("R4 R5 R7 9876");
    drive_live(16'h5432, 1'b0, 1'b0); @(negedge clk);
    m_dig = 16'h5432; m_half = 1'b0;
    check_frame("R4 R5 R7 5432");
    drive_live(16'hA1FB, 1'b1, 1'b1); @(negedge clk);
    m_dig = 16'hA1FB; m_half = 1'b1; m_neg = 1'b1;
    check_frame("R7 blank codes");
  endtask

  task automatic t_annunciators();
    cont_flag = 1'b1; lowbat_flag = 1'b0; dp_req = 4'b1010;
    drive_live(16'h8888, 1'b0, 1'b1); @(negedge clk);
    m_dig = 16'h8888; m_half = 1'b0; m_neg = 1'b1;
    check_frame("R6 R8 cont dp");
    cont_flag = 1'b0; lowbat_flag = 1'b1; dp_req = 4'b0101;
    drive_live(16'h0000, 1'b1, 1'b0); @(negedge clk);
    m_dig = 16'h0000; m_half = 1'b1; m_neg = 1'b0;
    check_frame("R6 R8 lowbat half");
    cont_flag = 1'b0; lowbat_flag = 1'b0; dp_req = 4'b0000;
  endtask

  task automatic t_strobe();
    latch_mode = 2'b00; strobe_n = 1'b1;
    drive_live(16'h1357, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check_all("R9 strobe idle ignored");
    strobe_n = 1'b0; @(negedge clk);
    m_dig = 16'h1357; m_half = 1'b0; m_neg = 1'b1;
    check_all("R9 strobe load");
    strobe_n = 1'b1; drive_live(16'h2468, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check_all("R9 strobe released keeps");
  endtask

  task automatic t_hold();
    latch_mode = 2'b01; strobe_n = 1'b0;
    drive_live(16'h9999, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check_all("R10 hold 01");
    latch_mode = 2'b11; drive_live(16'h4444, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check_all("R10 hold 11");
    latch_mode = 2'b00; @(negedge clk);
    m_dig = 16'h4444; m_half = 1'b0; m_neg = 1'b0;
    check_all("R9 load after hold");
    strobe_n = 1'b1;
  endtask

  task automatic t_transparent();
    latch_mode = 2'b10; @(negedge clk);
    drive_live(16'h7531, 1'b1, 1'b1);
    #1 check_all("R11 before edge");
    @(negedge clk);
    m_dig = 16'h7531; m_half = 1'b1; m_neg = 1'b1;
    check_all("R11 one clock later");
    drive_live(16'h0246, 1'b0, 1'b0); @(negedge clk);
    m_dig = 16'h0246; m_half = 1'b0; m_neg = 1'b0;
    check_all("R11 follows");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_slot_timing();
    t_digits();
    t_annunciators();
    t_strobe();
    t_hold();
    t_transparent();
    t_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired k=%0d exp completion", k);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule